// File: doc/BRIEF.md
# Integer 4x4 Forward Transform Engine

The engine turns a 4x4 block of signed 16-bit residual samples into 16 signed 16-bit transform coefficients. It uses a separable integer approximation of the DCT. Samples arrive as a valid/ready stream of one four-sample row per beat. Each accepted row goes straight through the horizontal pass, and the result is written as one row of a 4x4 holding buffer.

Once the fourth row is in, the engine runs the vertical pass. It reads one buffer column per cycle and writes that column's four results back into the same column. The buffer then holds the coefficients in raster order: the row index is the vertical frequency and the column index is the horizontal frequency. The engine sends the buffer out as four rows on a second valid/ready stream. Coefficients 0..3 come first.

The two passes differ:
- The horizontal pass pre-scales its butterfly terms by 8. Its odd outputs use a 12-bit shift with offsets 14500 and 7500.
- The vertical pass adds 7 to its even terms before a 4-bit shift. Its odd outputs use a 16-bit shift with offsets 12000 and 51000.
- The vertical pass also adds one to coefficient row 1 whenever its difference term is nonzero.

A three-state controller sequences the engine:
- ST_LOAD accepts rows. It moves to ST_COLUMN when the fourth row is taken.
- ST_COLUMN spends four cycles on the columns. It moves to ST_DRAIN after the last column.
- ST_DRAIN presents the output rows. It returns to ST_LOAD when the fourth row is accepted.

Top module: `fdct4x4_engine`

## Requirements
- R1: Horizontal even outputs. For an input row s0..s3, the terms are a=(s0+s3)<<3 and b=(s1+s2)<<3, in 16-bit wraparound arithmetic. The outputs are h0=a+b and h2=a-b.
- R2: Horizontal odd outputs. With c=(s1-s2)<<3 and d=(s0-s3)<<3, h1=(2217c+5352d+14500)>>>12 and h3=(2217d-5352c+7500)>>>12. Both use 32-bit signed products and sums, and the results are truncated to 16 bits.
- R3: Vertical even outputs. On a buffer column t0..t3 with a=t0+t3 and b=t1+t2 (16-bit wraparound, no pre-scale), the outputs are v0=(a+7+b)>>>4 and v2=(a+7-b)>>>4, both 16-bit arithmetic shifts.
- R4: Vertical odd outputs. With c=t1-t2 and d=t0-t3, v1=((2217c+5352d+12000)>>>16)+(d!=0 ? 1 : 0) and v3=(2217d-5352c+51000)>>>16, using 32-bit signed arithmetic and truncation to 16 bits.
- R5: Output order and packing. Exactly four output rows leave per block, and output row k holds the vertical-frequency-k results of columns 0..3. On both streams, element k sits in bits [16k+15:16k].
- R6: The input accepts exactly four row beats per block. in_ready stays low from the fourth accepted row until the fourth output row has been accepted, and in_valid is ignored while in_ready is low.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_row stays unchanged in the next cycle.
- R8: A synchronous active-high reset returns the engine to accepting a fresh block. After reset, in_ready is high and out_valid is low, and rows taken before reset play no part in the next block.
- R9: in_ready and out_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input row is present |
| in_ready | output | 1 | The engine accepts an input row this cycle |
| in_row | input | 4*DW | Four samples of one input row, element k in bits [DW*k+DW-1:DW*k] |
| out_valid | output | 1 | A coefficient row is present |
| out_ready | input | 1 | The consumer accepts the coefficient row |
| out_row | output | 4*DW | Four coefficients of one output row, same packing as the input |

## Verification
A wrong buffer write or a wrong phase count shows up in the coefficients of the block being processed. It also shows up as a handshake fault: a fifth input row accepted, an output row missing or repeated, or in_ready and out_valid high together. All of these appear at the ports within the 12-cycle window of one block. A wrong multiply constant, offset or shift, or a missing nonzero correction, corrupts specific coefficient positions. Comparison against a bit-exact model on random and extreme blocks exposes these on the first block that leaves the engine. A row that changes under backpressure is visible in the very next cycle.

// File: rtl/fdct4x4_pkg.sv
package fdct4x4_pkg;

    // Block edge length (rows per block, samples per row)
    localparam int N = 4;

    // Fixed-point multipliers shared by both passes
    localparam int K_LO = 2217;
    localparam int K_HI = 5352;

    // Horizontal pass scaling
    localparam int H_PRESHIFT = 3;
    localparam int H_RND_ODD1 = 14500;
    localparam int H_RND_ODD3 = 7500;
    localparam int H_SHIFT    = 12;

    // Vertical pass scaling
    localparam int V_RND_EVEN   = 7;
    localparam int V_SHIFT_EVEN = 4;
    localparam int V_RND_ODD1   = 12000;
    localparam int V_RND_ODD3   = 51000;
    localparam int V_SHIFT      = 16;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_COLUMN = 2'd1,
        ST_DRAIN  = 2'd2
    } phase_t;

endpackage

// File: rtl/fdct_odd_mac.sv
// Odd-coefficient multiply-accumulate pair shared by both passes.
module fdct_odd_mac
    import fdct4x4_pkg::*;
#(
    parameter int DW    = 16,
    parameter int RND1  = 0,
    parameter int RND3  = 0,
    parameter int SHIFT = 12
) (
    input  logic signed [DW-1:0] c_in,
    input  logic signed [DW-1:0] d_in,
    output logic signed [DW-1:0] odd1,
    output logic signed [DW-1:0] odd3
);
    localparam int AW = 2 * DW;
    localparam logic signed [AW-1:0] KL = AW'(K_LO);
    localparam logic signed [AW-1:0] KH = AW'(K_HI);
    localparam logic signed [AW-1:0] R1 = AW'(RND1);
    localparam logic signed [AW-1:0] R3 = AW'(RND3);

    logic signed [AW-1:0] c_w;
    logic signed [AW-1:0] d_w;
    logic signed [AW-1:0] acc1;
    logic signed [AW-1:0] acc3;

    always_comb begin
        c_w  = c_in;
        d_w  = d_in;
        acc1 = c_w * KL + d_w * KH + R1;
        acc3 = d_w * KL - c_w * KH + R3;
        odd1 = DW'(acc1 >>> SHIFT);
        odd3 = DW'(acc3 >>> SHIFT);
    end
endmodule

// File: rtl/fdct_pass.sv
// One 4-point pass; VERTICAL selects the scaling variant.
module fdct_pass
    import fdct4x4_pkg::*;
#(
    parameter int DW       = 16,
    parameter bit VERTICAL = 1'b0
) (
    input  logic [N*DW-1:0] vec_in,
    output logic [N*DW-1:0] vec_out
);
    localparam int PRE = VERTICAL ? 0 : H_PRESHIFT;
    localparam int RO1 = VERTICAL ? V_RND_ODD1 : H_RND_ODD1;
    localparam int RO3 = VERTICAL ? V_RND_ODD3 : H_RND_ODD3;
    localparam int SHO = VERTICAL ? V_SHIFT : H_SHIFT;

    logic signed [DW-1:0] smp [N];
    logic signed [DW-1:0] res [N];
    logic signed [DW-1:0] sum03, sum12, dif12, dif03;
    logic signed [DW-1:0] t_a, t_b, t_c, t_d;
    logic signed [DW-1:0] odd1, odd3;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_io
            assign smp[gi] = vec_in[gi*DW +: DW];
            assign vec_out[gi*DW +: DW] = res[gi];
        end
    endgenerate

    always_comb begin
        sum03 = smp[0] + smp[3];
        sum12 = smp[1] + smp[2];
        dif12 = smp[1] - smp[2];
        dif03 = smp[0] - smp[3];
        t_a   = sum03 <<< PRE;
        t_b   = sum12 <<< PRE;
        t_c   = dif12 <<< PRE;
        t_d   = dif03 <<< PRE;
    end

    fdct_odd_mac #(
        .DW   (DW),
        .RND1 (RO1),
        .RND3 (RO3),
        .SHIFT(SHO)
    ) u_odd (
        .c_in(t_c),
        .d_in(t_d),
        .odd1(odd1),
        .odd3(odd3)
    );

    generate
        if (VERTICAL) begin : g_vert
            localparam logic signed [DW-1:0] RND_E = DW'(V_RND_EVEN);
            logic signed [DW-1:0] e_sum, e_dif, nz_inc;
            always_comb begin
                e_sum  = t_a + RND_E + t_b;
                e_dif  = t_a + RND_E - t_b;
                nz_inc = {{(DW-1){1'b0}}, (t_d != '0)};
                res[0] = e_sum >>> V_SHIFT_EVEN;
                res[1] = odd1 + nz_inc;
                res[2] = e_dif >>> V_SHIFT_EVEN;
                res[3] = odd3;
            end
        end else begin : g_horiz
            always_comb begin
                res[0] = t_a + t_b;
                res[1] = odd1;
                res[2] = t_a - t_b;
                res[3] = odd3;
            end
        end
    endgenerate
endmodule

// File: rtl/fdct_ctrl.sv
// Phase controller: load rows, process columns, drain rows.
module fdct_ctrl
    import fdct4x4_pkg::*;
#(
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          load_we,
    output logic          col_we,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    phase_t        state, state_nx;
    logic [IW-1:0] step, step_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOAD;
            step  <= '0;
        end else begin
            state <= state_nx;
            step  <= step_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        step_nx  = step;
        unique case (state)
            ST_LOAD: begin
                if (in_valid) begin
                    step_nx = step + 1'b1;
                    if (step == LAST) state_nx = ST_COLUMN;
                end
            end
            ST_COLUMN: begin
                step_nx = step + 1'b1;
                if (step == LAST) state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (out_ready) begin
                    step_nx = step + 1'b1;
                    if (step == LAST) state_nx = ST_LOAD;
                end
            end
            default: begin
                state_nx = ST_LOAD;
                step_nx  = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        col_we    = 1'b0;
        unique case (state)
            ST_LOAD:   in_ready  = 1'b1;
            ST_COLUMN: col_we    = 1'b1;
            ST_DRAIN:  out_valid = 1'b1;
            default:   ;
        endcase
        load_we = in_ready & in_valid;
        idx     = step;
    end
endmodule

// File: rtl/fdct4x4_engine.sv
module fdct4x4_engine
    import fdct4x4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [N*DW-1:0] in_row,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [N*DW-1:0] out_row
);
    localparam int IW = $clog2(N);

    logic          load_we;
    logic          col_we;
    logic [IW-1:0] idx;

    logic [DW-1:0]   tbuf [N][N];
    logic [N*DW-1:0] h_out;
    logic [N*DW-1:0] v_in;
    logic [N*DW-1:0] v_out;

    fdct_ctrl #(.IW(IW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .load_we  (load_we),
        .col_we   (col_we),
        .idx      (idx)
    );

    fdct_pass #(.DW(DW), .VERTICAL(1'b0)) u_hpass (
        .vec_in (in_row),
        .vec_out(h_out)
    );

    fdct_pass #(.DW(DW), .VERTICAL(1'b1)) u_vpass (
        .vec_in (v_in),
        .vec_out(v_out)
    );

    genvar gk;
    generate
        for (gk = 0; gk < N; gk++) begin : g_sel
            assign v_in[gk*DW +: DW]    = tbuf[gk][idx];
            assign out_row[gk*DW +: DW] = tbuf[idx][gk];
        end
    endgenerate

    // Row write on input, in-place column write-back in the column phase
    always_ff @(posedge clk) begin
        if (load_we) begin
            for (int k = 0; k < N; k++) tbuf[idx][k] <= h_out[k*DW +: DW];
        end else if (col_we) begin
            for (int k = 0; k < N; k++) tbuf[k][idx] <= v_out[k*DW +: DW];
        end
    end
endmodule

// File: rtl/fdct4x4_checker.sv
module fdct4x4_checker
    import fdct4x4_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [N*DW-1:0] out_row
);
    logic [3:0] rows_in;
    logic [3:0] rows_out;
    logic       in_fire, out_fire;

    assign in_fire  = in_valid & in_ready;
    assign out_fire = out_valid & out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_in  <= '0;
            rows_out <= '0;
        end else if (out_fire && rows_out == 4'(N - 1)) begin
            rows_in  <= '0;
            rows_out <= '0;
        end else begin
            if (in_fire)  rows_in  <= rows_in + 1'b1;
            if (out_fire) rows_out <= rows_out + 1'b1;
        end
    end

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    assert_hold_row_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    assert_four_inputs_R6: assert property (@(posedge clk) disable iff (rst)
        in_fire |-> (rows_in < 4'(N)));

    assert_drain_after_load_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (rows_in == 4'(N) && rows_out == 4'd0));

    assert_four_outputs_R5: assert property (@(posedge clk) disable iff (rst)
        out_fire |-> (rows_in == 4'(N) && rows_out < 4'(N)));

    assert_blocked_while_full_R6: assert property (@(posedge clk) disable iff (rst)
        (rows_in == 4'(N)) |-> !in_ready);
endmodule

bind fdct4x4_engine fdct4x4_checker #(.DW(DW)) i_fdct4x4_checker (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_row  (out_row)
);

// File: tb/test_fdct4x4_engine.sv
module test_fdct4x4_engine;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [63:0]   in_row = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [63:0]   out_row;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic signed [15:0] blk  [16];
    logic signed [15:0] expv [16];
    logic signed [15:0] got  [16];

    always #10 clk = ~clk;

    fdct4x4_engine #(.DW(DW)) i_fdct4x4_engine (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_row   (in_row),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_row  (out_row)
    );

    function automatic logic signed [15:0] w16(int v);
        return 16'(v);
    endfunction

    // Bit-exact model of both passes
    function automatic void model();
        int t[16];
        int x0, x1, x2, x3, a, b, c, d;
        for (int r = 0; r < 4; r++) begin
            x0 = blk[r*4]; x1 = blk[r*4+1]; x2 = blk[r*4+2]; x3 = blk[r*4+3];
            a = w16(int'(w16(x0 + x3)) * 8);
            b = w16(int'(w16(x1 + x2)) * 8);
            c = w16(int'(w16(x1 - x2)) * 8);
            d = w16(int'(w16(x0 - x3)) * 8);
            t[r*4]   = w16(a + b);
            t[r*4+2] = w16(a - b);
            t[r*4+1] = w16((c*2217 + d*5352 + 14500) >>> 12);
            t[r*4+3] = w16((d*2217 - c*5352 + 7500) >>> 12);
        end
        for (int j = 0; j < 4; j++) begin
            x0 = t[j]; x1 = t[4+j]; x2 = t[8+j]; x3 = t[12+j];
            a = w16(x0 + x3);
            b = w16(x1 + x2);
            c = w16(x1 - x2);
            d = w16(x0 - x3);
            expv[j]    = w16(int'(w16(int'(w16(a + 7)) + b)) >>> 4);
            expv[8+j]  = w16(int'(w16(int'(w16(a + 7)) - b)) >>> 4);
            expv[4+j]  = w16(int'(w16((c*2217 + d*5352 + 12000) >>> 16)) + ((d != 0) ? 1 : 0));
            expv[12+j] = w16((d*2217 - c*5352 + 51000) >>> 16);
        end
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_rows(bit junk);
        @(negedge clk);
        for (int r = 0; r < 4; r++) begin
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_row   = {blk[r*4+3], blk[r*4+2], blk[r*4+1], blk[r*4]};
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(!in_ready, "R6 ready after fourth row", int'(in_ready), 0);
        if (junk) begin
            in_valid = 1'b1;
            in_row   = {$urandom(), $urandom()};
        end
    endtask

    task automatic recv_rows(bit bp);
        int row = 0;
        bit held_v = 0;
        logic [63:0] held = '0;
        while (row < 4) begin
            @(negedge clk);
            if (out_valid) begin
                check(!in_ready, "R9 ready during drain", int'(in_ready), 0);
                if (held_v)
                    check(out_row == held, "R7 row held", int'(out_row[15:0]), int'(held[15:0]));
                out_ready = bp ? 1'($urandom_range(1)) : 1'b1;
                if (out_ready) begin
                    for (int k = 0; k < 4; k++) got[row*4+k] = out_row[k*16 +: 16];
                    row++;
                    held_v = 0;
                end else begin
                    held   = out_row;
                    held_v = 1;
                end
            end else begin
                out_ready = 1'b0;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid, "R5 only four rows", int'(out_valid), 0);
        check(in_ready, "R6 ready after drain", int'(in_ready), 1);
    endtask

    task automatic run_block(bit bp, bit junk);
        model();
        fork
            send_rows(junk);
            recv_rows(bp);
        join
        in_valid = 1'b0;
        for (int i = 0; i < 16; i++) begin
            string tag;
            if ((i / 4) % 2 == 0)
                tag = ((i % 2) == 0) ? "R1 R3 R5 coef" : "R2 R3 R5 coef";
            else
                tag = ((i % 2) == 0) ? "R1 R4 R5 coef" : "R2 R4 R5 coef";
            check(got[i] == expv[i], tag, int'(got[i]), int'(expv[i]));
        end
    endtask

    function automatic void fill_random();
        for (int i = 0; i < 16; i++) blk[i] = w16(int'($urandom_range(510)) - 255);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R8 reset out_valid", int'(out_valid), 0);
        check(in_ready, "R8 reset in_ready", int'(in_ready), 1);

        for (int i = 0; i < 16; i++) blk[i] = 16'sd0;
        run_block(1'b0, 1'b0);

        for (int i = 0; i < 16; i++) blk[i] = 16'sd255;
        run_block(1'b1, 1'b0);

        for (int i = 0; i < 16; i++) blk[i] = ((i + i / 4) % 2 == 0) ? 16'sd255 : -16'sd255;
        run_block(1'b0, 1'b1);

        for (int i = 0; i < 16; i++) blk[i] = ($urandom_range(1) == 1) ? 16'sd255 : -16'sd255;
        run_block(1'b1, 1'b1);

        // Partial block, then reset: stale rows must not leak
        fill_random();
        @(negedge clk);
        for (int r = 0; r < 2; r++) begin
            in_valid = 1'b1;
            in_row   = {blk[r*4+3], blk[r*4+2], blk[r*4+1], blk[r*4]};
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R8 reset mid-block out_valid", int'(out_valid), 0);
        check(in_ready, "R8 reset mid-block in_ready", int'(in_ready), 1);
        fill_random();
        run_block(1'b0, 1'b0);

        for (int n = 0; n < 40; n++) begin
            fill_random();
            run_block(1'(n % 2), 1'(n % 3 == 0));
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule